// File: doc/BRIEF.md
# Indexed Register Port Slave

This block is the host-bus face of a network controller. The host sees only two locations in a small I/O window, and both share one 16-bit data bus. The `bus_cmd` input tells them apart. A write with `bus_cmd` low loads an 8-bit register number into an index latch. Any access with `bus_cmd` high then acts on the register that the latch names. Behind the latch sit eight general byte-wide registers, a transmit control register, an interrupt status register and an interrupt mask register.

Three index values stream data instead of naming a register:

- **Push index:** each data-port write sends one 16-bit word to an external transmit buffer, and the transmit pointer moves on by two bytes.
- **Pull index:** each data-port read returns the word at the receive pointer, and that pointer moves on by two bytes.
- **Peek index:** a read returns the low byte of the current receive word and leaves the pointer where it is.

Both pointers wrap at their buffer size.

The transmit request bit is set by the host and clears when the media side reports that the frame has gone. The interrupt status bits are raised by events and cleared by writing ones to them.

Top module: `idx_port_slave`

## Requirements
- R1: An access is taken only when `bus_aen_n` is 0 and `bus_addr` (address lines 9 to 4) equals 6'b110000, the window at 0x300. Otherwise writes change nothing, no word is streamed and `bus_rdata` is 0.
- R2: A write with `bus_cmd`=0 loads `bus_wdata[7:0]` into the index latch and changes no register. A read with `bus_cmd`=0 returns the index zero-extended.
- R3: Indices 0x10 to 0x17 are eight byte registers. A data-port write stores `bus_wdata[7:0]`, and a read returns the byte with bits 15 to 8 zero.
- R4: Index 0x02 bit 0 is the transmit request. Writing 1 sets it, and `tx_req` and the read-back stay 1 until a `tx_done` pulse. That pulse clears the bit and sets status bit 1.
- R5: Index 0xFE is the status register. Bit 0 is set by an `rx_pkt` pulse and bit 1 by transmit completion. Writing 1 to a bit clears it and writing 0 leaves it alone. If a set event and a clear arrive in the same cycle, the set wins.
- R6: Index 0xFF holds a 2-bit mask, and `irq` is the OR of (status AND mask).
- R7: At index 0xF8, each data-port write drives `tx_wr_en` for that cycle with `tx_wr_addr` equal to the transmit pointer and `tx_wr_data` equal to `bus_wdata`. The pointer then advances by 2 and wraps at the buffer size (64 bytes by default).
- R8: At index 0xF2, a data-port read returns `rx_rd_data` from address `rx_rd_addr`. The receive pointer then advances by 2 and wraps at the buffer size.
- R9: At index 0xF0, a data-port read returns `rx_rd_data[7:0]` zero-extended and does not move the receive pointer.
- R10: A synchronous reset clears the index, the byte registers, the transmit request, status, mask and both pointers. Unmapped indices read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_aen_n | input | 1 | Address enable, active low |
| bus_addr | input | 6 | Host address lines 9 to 4 |
| bus_cmd | input | 1 | 0 selects the index port, 1 selects the data port |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid while `bus_rd` is high |
| tx_wr_en | output | 1 | Transmit buffer word write |
| tx_wr_addr | output | 6 | Transmit buffer byte address |
| tx_wr_data | output | 16 | Transmit buffer word |
| rx_rd_addr | output | 6 | Receive buffer byte address |
| rx_rd_data | input | 16 | Receive buffer word at `rx_rd_addr` |
| rx_pkt | input | 1 | Pulse: a packet was received |
| tx_done | input | 1 | Pulse: the requested frame was sent |
| tx_req | output | 1 | Transmit request pending |
| irq | output | 1 | Masked interrupt request |

## Verification
The bench covers these corner cases:

- **Access from outside the window.** An access with the enable high or with a foreign address must leave the index untouched. A decoder that ignored either input would overwrite the index and stream a stray word.
- **Pointer wrap.** The transmit pointer is pushed through a full wrap. A design with the wrong step or no wrap would emit the wrong addresses.
- **Peek between pulls.** A peek is issued between pulls. A design that advanced on a peek would skip a receive word.
- **Clearing status bits.** Zeros are written to the status register and then ones. A plain-write design would clear bits on the zero write, and a sticky design would never clear them.

// File: rtl/idx_port_pkg.sv
package idx_port_pkg;
    localparam int IDX_W  = 8;
    localparam int DATA_W = 16;

    localparam logic [IDX_W-1:0] IDX_TXCTL  = 8'h02;
    localparam logic [IDX_W-1:0] IDX_RXPEEK = 8'hF0;
    localparam logic [IDX_W-1:0] IDX_RXPULL = 8'hF2;
    localparam logic [IDX_W-1:0] IDX_TXPUSH = 8'hF8;
    localparam logic [IDX_W-1:0] IDX_STAT   = 8'hFE;
    localparam logic [IDX_W-1:0] IDX_MASK   = 8'hFF;
    localparam logic [IDX_W-1:0] GP_BASE    = 8'h10;
    localparam int GP_N = 8;

    typedef enum logic [2:0] {
        K_NONE, K_GP, K_TXCTL, K_STAT, K_MASK, K_TXPUSH, K_RXPULL, K_RXPEEK
    } target_e;

    typedef struct packed {
        logic              rd;
        logic              wr;
        logic              cmd;
        logic [DATA_W-1:0] data;
    } bus_op_t;

    function automatic target_e classify(input logic [IDX_W-1:0] idx);
        if (idx >= GP_BASE && idx < IDX_W'(GP_BASE + GP_N)) return K_GP;
        case (idx)
            IDX_TXCTL:  return K_TXCTL;
            IDX_STAT:   return K_STAT;
            IDX_MASK:   return K_MASK;
            IDX_TXPUSH: return K_TXPUSH;
            IDX_RXPULL: return K_RXPULL;
            IDX_RXPEEK: return K_RXPEEK;
            default:    return K_NONE;
        endcase
    endfunction
endpackage

// File: rtl/idx_addr_decode.sv
module idx_addr_decode #(
    parameter int             AW   = 6,
    parameter logic [AW-1:0]  BASE = 6'b110000
) (
    input  logic          aen_n,
    input  logic [AW-1:0] addr,
    output logic          sel
);
    always_comb sel = !aen_n && (addr == BASE);
endmodule

// File: rtl/idx_byte_regs.sv
module idx_byte_regs #(
    parameter int N  = 8,
    parameter int W  = 8,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] regs [N];

    for (genvar g = 0; g < N; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[g] <= '0;
            else if (we && addr == AW'(g))
                regs[g] <= wdata;
        end
    end

    always_comb rdata = regs[addr];
endmodule

// File: rtl/idx_stream_ptr.sv
module idx_stream_ptr #(
    parameter int BYTES = 64,
    localparam int PW = $clog2(BYTES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    output logic [PW-1:0] ptr
);
    always_ff @(posedge clk) begin
        if (rst)
            ptr <= '0;
        else if (step)
            ptr <= ptr + PW'(2);
    end
endmodule

// File: rtl/idx_port_slave.sv
module idx_port_slave
    import idx_port_pkg::*;
#(
    parameter int           TX_BYTES = 64,
    parameter int           RX_BYTES = 64,
    parameter logic [5:0]   BASE     = 6'b110000,
    localparam int TXW = $clog2(TX_BYTES),
    localparam int RXW = $clog2(RX_BYTES),
    localparam int GAW = $clog2(GP_N)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_aen_n,
    input  logic [5:0]        bus_addr,
    input  logic              bus_cmd,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              tx_wr_en,
    output logic [TXW-1:0]    tx_wr_addr,
    output logic [DATA_W-1:0] tx_wr_data,
    output logic [RXW-1:0]    rx_rd_addr,
    input  logic [DATA_W-1:0] rx_rd_data,
    input  logic              rx_pkt,
    input  logic              tx_done,
    output logic              tx_req,
    output logic              irq
);
    logic       sel;
    bus_op_t    op;
    logic [IDX_W-1:0] idx_q;
    target_e    tgt;
    logic       dwr, drd;
    logic [1:0] stat_q, mask_q;
    logic [7:0] gp_rdata;
    logic       gp_we;

    idx_addr_decode #(.AW(6), .BASE(BASE)) u_dec (
        .aen_n(bus_aen_n), .addr(bus_addr), .sel(sel)
    );

    always_comb begin
        op.rd   = sel && bus_rd;
        op.wr   = sel && bus_wr;
        op.cmd  = bus_cmd;
        op.data = bus_wdata;
        tgt     = classify(idx_q);
        dwr     = op.wr && op.cmd;
        drd     = op.rd && op.cmd;
        gp_we   = dwr && (tgt == K_GP);
    end

    always_ff @(posedge clk) begin
        if (rst)
            idx_q <= '0;
        else if (op.wr && !op.cmd)
            idx_q <= op.data[IDX_W-1:0];
    end

    idx_byte_regs #(.N(GP_N), .W(8)) u_regs (
        .clk(clk), .rst(rst), .we(gp_we),
        .addr(GAW'(idx_q - GP_BASE)), .wdata(op.data[7:0]), .rdata(gp_rdata)
    );

    idx_stream_ptr #(.BYTES(TX_BYTES)) u_txp (
        .clk(clk), .rst(rst), .step(dwr && tgt == K_TXPUSH), .ptr(tx_wr_addr)
    );

    idx_stream_ptr #(.BYTES(RX_BYTES)) u_rxp (
        .clk(clk), .rst(rst), .step(drd && tgt == K_RXPULL), .ptr(rx_rd_addr)
    );

    always_comb begin
        tx_wr_en   = dwr && (tgt == K_TXPUSH);
        tx_wr_data = op.data;
    end

    // transmit request: completion wins over a fresh set in the same cycle
    always_ff @(posedge clk) begin
        if (rst)
            tx_req <= 1'b0;
        else if (tx_req && tx_done)
            tx_req <= 1'b0;
        else if (dwr && tgt == K_TXCTL && op.data[0])
            tx_req <= 1'b1;
    end

    logic [1:0] stat_set, stat_clr;
    always_comb begin
        stat_set = {tx_req && tx_done, rx_pkt};
        stat_clr = (dwr && tgt == K_STAT) ? op.data[1:0] : 2'b00;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
            mask_q <= '0;
        end else begin
            stat_q <= (stat_q & ~stat_clr) | stat_set;
            if (dwr && tgt == K_MASK)
                mask_q <= op.data[1:0];
        end
    end

    always_comb irq = |(stat_q & mask_q);

    always_comb begin
        bus_rdata = '0;
        if (op.rd) begin
            if (!op.cmd)
                bus_rdata = {8'h00, idx_q};
            else begin
                case (tgt)
                    K_GP:     bus_rdata = {8'h00, gp_rdata};
                    K_TXCTL:  bus_rdata = {15'b0, tx_req};
                    K_STAT:   bus_rdata = {14'b0, stat_q};
                    K_MASK:   bus_rdata = {14'b0, mask_q};
                    K_RXPULL: bus_rdata = rx_rd_data;
                    K_RXPEEK: bus_rdata = {8'h00, rx_rd_data[7:0]};
                    default:  bus_rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/idx_port_slave_chk.sv
module idx_port_slave_chk #(
    parameter int TXW = 6,
    parameter int RXW = 6
) (
    input logic           clk,
    input logic           rst,
    input logic           bus_aen_n,
    input logic [5:0]     bus_addr,
    input logic           bus_cmd,
    input logic           bus_rd,
    input logic           bus_wr,
    input logic [15:0]    bus_wdata,
    input logic           tx_wr_en,
    input logic [TXW-1:0] tx_wr_addr,
    input logic [RXW-1:0] rx_rd_addr,
    input logic           rx_pkt,
    input logic           tx_done,
    input logic           tx_req,
    input logic [7:0]     idx_q,
    input logic [1:0]     stat_q
);
    logic in_win;
    always_comb in_win = !bus_aen_n && bus_addr == 6'b110000;

    a_r1_no_stream_outside: assert property (@(posedge clk) disable iff (rst)
        !in_win |-> !tx_wr_en);

    a_r2_index_load: assert property (@(posedge clk) disable iff (rst)
        (in_win && bus_wr && !bus_cmd) |=> idx_q == $past(bus_wdata[7:0]));

    a_r4_req_clears: assert property (@(posedge clk) disable iff (rst)
        (tx_req && tx_done) |=> !tx_req);

    a_r5_rx_sets_status: assert property (@(posedge clk) disable iff (rst)
        rx_pkt |=> stat_q[0]);

    a_r7_tx_ptr_step: assert property (@(posedge clk) disable iff (rst)
        tx_wr_en |=> tx_wr_addr == TXW'($past(tx_wr_addr) + TXW'(2)));

    a_r8_rx_ptr_hold: assert property (@(posedge clk) disable iff (rst)
        !(in_win && bus_rd && bus_cmd && idx_q == 8'hF2) |=> $stable(rx_rd_addr));
endmodule

bind idx_port_slave idx_port_slave_chk #(.TXW(TXW), .RXW(RXW)) u_chk (
    .clk(clk), .rst(rst), .bus_aen_n(bus_aen_n), .bus_addr(bus_addr),
    .bus_cmd(bus_cmd), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .tx_wr_en(tx_wr_en), .tx_wr_addr(tx_wr_addr), .rx_rd_addr(rx_rd_addr),
    .rx_pkt(rx_pkt), .tx_done(tx_done), .tx_req(tx_req),
    .idx_q(idx_q), .stat_q(stat_q)
);

// File: tb/idx_port_slave_test.sv
module idx_port_slave_test;
    logic        clk = 0;
    logic        rst = 1;
    logic        bus_aen_n = 1;
    logic [5:0]  bus_addr = 6'b110000;
    logic        bus_cmd = 0, bus_rd = 0, bus_wr = 0;
    logic [15:0] bus_wdata = 0;
    logic [15:0] bus_rdata;
    logic        tx_wr_en;
    logic [5:0]  tx_wr_addr, rx_rd_addr;
    logic [15:0] tx_wr_data, rx_rd_data;
    logic        rx_pkt = 0, tx_done = 0, tx_req, irq;

    int checks = 0, fails = 0;
    logic done = 0;

    always #10 clk = ~clk;

    // receive buffer model: high byte A5, low byte the byte address
    assign rx_rd_data = {8'hA5, 2'b00, rx_rd_addr};

    idx_port_slave uut (
        .clk(clk), .rst(rst), .bus_aen_n(bus_aen_n), .bus_addr(bus_addr),
        .bus_cmd(bus_cmd), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .tx_wr_en(tx_wr_en), .tx_wr_addr(tx_wr_addr),
        .tx_wr_data(tx_wr_data), .rx_rd_addr(rx_rd_addr), .rx_rd_data(rx_rd_data),
        .rx_pkt(rx_pkt), .tx_done(tx_done), .tx_req(tx_req), .irq(irq)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic c, input logic [15:0] d);
        @(negedge clk);
        bus_aen_n = 0; bus_cmd = c; bus_wdata = d; bus_wr = 1;
        @(negedge clk);
        bus_wr = 0; bus_aen_n = 1;
    endtask

    task automatic rd(input logic c, output logic [15:0] d);
        @(negedge clk);
        bus_aen_n = 0; bus_cmd = c; bus_rd = 1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 0; bus_aen_n = 1;
    endtask

    task automatic reg_wr(input logic [7:0] i, input logic [15:0] d);
        wr(0, {8'h00, i}); wr(1, d);
    endtask

    task automatic reg_rd(input logic [7:0] i, output logic [15:0] d);
        wr(0, {8'h00, i}); rd(1, d);
    endtask

    task automatic pulse(ref logic s);
        @(negedge clk); s = 1;
        @(negedge clk); s = 0;
    endtask

    task automatic t_reset;
        logic [15:0] v;
        check("R10 tx_req after reset", {15'b0, tx_req}, 16'h0);
        check("R10 irq after reset", {15'b0, irq}, 16'h0);
        check("R10 rx ptr after reset", {10'b0, rx_rd_addr}, 16'h0);
        rd(0, v); check("R10 index after reset", v, 16'h0000);
        reg_rd(8'h15, v); check("R10 byte reg after reset", v, 16'h0000);
        reg_rd(8'h40, v); check("R10 unmapped reads 0", v, 16'h0000);
    endtask

    task automatic t_index_and_regs;
        logic [15:0] v;
        reg_wr(8'h13, 16'hBEEF);
        reg_rd(8'h13, v); check("R3 byte reg zero-extended", v, 16'h00EF);
        rd(0, v); check("R2 index read back", v, 16'h0013);
        reg_wr(8'h17, 16'h0042);
        reg_rd(8'h13, v); check("R3 neighbour untouched", v, 16'h00EF);
        wr(0, 16'h0013);
        reg_rd(8'h17, v); check("R2 index write has no register effect", v, 16'h0042);
    endtask

    task automatic t_decode;
        logic [15:0] v;
        wr(0, 16'h0013);
        @(negedge clk); bus_aen_n = 1; bus_cmd = 0; bus_wdata = 16'h0017; bus_wr = 1;
        @(negedge clk); bus_wr = 0;
        @(negedge clk); bus_aen_n = 0; bus_addr = 6'b110001; bus_cmd = 0; bus_wdata = 16'h0017; bus_wr = 1;
        @(negedge clk); bus_wr = 0; bus_rd = 1; bus_cmd = 0;
        #1 check("R1 read outside window is 0", bus_rdata, 16'h0000);
        @(negedge clk); bus_rd = 0; bus_aen_n = 1; bus_addr = 6'b110000;
        rd(0, v); check("R1 index unchanged by foreign access", v, 16'h0013);
    endtask

    task automatic t_txreq;
        logic [15:0] v;
        reg_wr(8'hFF, 16'h0003);
        reg_wr(8'h02, 16'h0001);
        check("R4 tx_req set", {15'b0, tx_req}, 16'h1);
        rd(1, v); check("R4 request reads 1 while pending", v, 16'h0001);
        pulse(tx_done);
        check("R4 tx_req clears on done", {15'b0, tx_req}, 16'h0);
        reg_rd(8'hFE, v); check("R4 completion sets status bit 1", v, 16'h0002);
        check("R6 irq from status bit 1", {15'b0, irq}, 16'h1);
        wr(1, 16'h0002);
        check("R6 irq drops after clear", {15'b0, irq}, 16'h0);
    endtask

    task automatic t_status;
        logic [15:0] v;
        pulse(rx_pkt);
        reg_rd(8'hFE, v); check("R5 rx sets bit 0", v, 16'h0001);
        check("R6 irq with mask", {15'b0, irq}, 16'h1);
        wr(1, 16'h0000);
        rd(1, v); check("R5 writing 0 keeps bit", v, 16'h0001);
        wr(1, 16'h0001);
        rd(1, v); check("R5 writing 1 clears bit", v, 16'h0000);
        pulse(rx_pkt);
        reg_wr(8'hFF, 16'h0002);
        check("R6 masked bit gives no irq", {15'b0, irq}, 16'h0);
        // set and clear in the same cycle: set wins
        wr(0, 16'h00FE);
        @(negedge clk); bus_aen_n = 0; bus_cmd = 1; bus_wdata = 16'h0001; bus_wr = 1; rx_pkt = 1;
        @(negedge clk); bus_wr = 0; rx_pkt = 0; bus_aen_n = 1;
        rd(1, v); check("R5 set wins over clear", v, 16'h0001);
        wr(1, 16'h0001);
    endtask

    task automatic t_txpush;
        wr(0, 16'h00F8);
        for (int k = 0; k < 34; k++) begin
            @(negedge clk);
            bus_aen_n = 0; bus_cmd = 1; bus_wdata = 16'h1000 + 16'(k); bus_wr = 1;
            #1;
            if (k == 0 || k == 31 || k == 32 || k == 33) begin
                check("R7 tx_wr_en", {15'b0, tx_wr_en}, 16'h1);
                check("R7 tx address with wrap", {10'b0, tx_wr_addr}, 16'((2 * k) % 64));
                check("R7 tx data", tx_wr_data, 16'h1000 + 16'(k));
            end
        end
        @(negedge clk); bus_wr = 0; bus_aen_n = 1;
        #1 check("R7 no stream when idle", {15'b0, tx_wr_en}, 16'h0);
    endtask

    task automatic t_rx;
        logic [15:0] v;
        wr(0, 16'h00F2);
        rd(1, v); check("R8 first pull", v, 16'hA500);
        rd(1, v); check("R8 second pull", v, 16'hA502);
        wr(0, 16'h00F0);
        rd(1, v); check("R9 peek low byte", v, 16'h0004);
        rd(1, v); check("R9 peek again, no advance", v, 16'h0004);
        wr(0, 16'h00F2);
        rd(1, v); check("R8 pull after peek", v, 16'hA504);
        for (int k = 0; k < 29; k++) rd(1, v);
        check("R8 last word before wrap", v, 16'hA53E);
        rd(1, v); check("R8 wrap to 0", v, 16'hA500);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_index_and_regs();
        t_decode();
        t_txreq();
        t_status();
        t_txpush();
        t_rx();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule